// File: doc/BRIEF.md
# SM4 Iterated Block Cipher Core

This block runs the SM4 128-bit block cipher one round per clock. A single-cycle `start` strobe captures a 128-bit input block. The core then spends 32 cycles on the rounds. In each busy cycle it presents a round index on `rk_idx` and reads back the matching 32-bit round key on `rk_data` in that same cycle. The key source is an external key RAM or a key port with a combinational read.

When the last round has been applied, the result is registered on `block_out` and `done` pulses high for one cycle. Decryption uses the same hardware. The key source answers index i with round key 31-i, and the ciphertext is fed in as the block.

The byte substitution is not stored as a native table. Each byte goes through three steps:
1. A field-conversion affine map, built from two 16-entry nibble lookups whose outputs are XORed.
2. The AES forward S-box, computed as a GF(2^8) inverse followed by the AES affine map.
3. A second nibble-lookup affine map that converts the byte back.

Key expansion, chaining modes and bus wrappers belong to surrounding logic.

Top module: `sm4_iter_core`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done`, `rk_idx` and `block_out` are all zero.
- R2: A `start` seen while idle captures `block_in` and raises `busy` in the next cycle. The captured block is split into four 32-bit big-endian state words, with word 0 taken from bits 127:96.
- R3: While busy, `rk_idx` steps through 0, 1, ..., 31, one value per cycle. The word on `rk_data` in the cycle where `rk_idx` equals i is the key used by round i.
- R4: Each round forms X = s1 ^ s2 ^ s3 ^ rk and substitutes every byte of X to give B. It then computes L(B) = B ^ rol(B,2) ^ rol(B,10) ^ rol(B,18) ^ rol(B,24) and moves the state (s0,s1,s2,s3) to (s1,s2,s3,s0 ^ L(B)).
- R5: The byte substitution equals the SM4 S-box (for example 0x00 maps to 0xD6 and 0xFF maps to 0x48). It is built as an input affine map, then the AES forward S-box, then an output affine map.
- R6: `done` is high for exactly one cycle, in the cycle after the 32nd round. That is 33 cycles after the cycle in which `start` was driven. `busy` is low in that cycle.
- R7: `block_out` carries the final words in reversed order {X35, X34, X33, X32}, each big-endian, with X35 in bits 127:96. It changes only when `done` rises and holds its value otherwise.
- R8: A `start` seen while busy is ignored. The running block, the key index sequence and the completion time are unchanged, even when the `start` falls in the last round cycle.
- R9: A `start` issued in the same cycle as `done` is accepted, so a new block begins back to back with the previous one.
- R10: Running the ciphertext with the round keys supplied in reverse order returns the original plaintext.
- R11: With key and plaintext 0123456789abcdeffedcba9876543210, the result is 681edf34d206965e86b3e94f536e4246.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle strobe that begins a block when idle |
| block_in | input | 128 | Input block, first byte in bits 127:120 |
| rk_data | input | 32 | Round key for the index on `rk_idx`, valid in the same cycle |
| rk_idx | output | 5 | Index of the round key needed this cycle |
| busy | output | 1 | High while rounds are running |
| done | output | 1 | One-cycle completion pulse |
| block_out | output | 128 | Result block, held until the next completion |

## Verification
Two events can fall in the same cycle: the completion pulse and the acceptance of a new `start`. They must both take effect.

The bench raises `start` with a fresh block in the very cycle it sees `done`. It then checks three things: that the first result is intact, that `busy` rises at once, and that the second block finishes 33 cycles later with its own correct value.

The neighbouring case is also covered. A `start` placed in the last round cycle, while `busy` is still high, must be dropped. The bench confirms this by observing the unchanged result and the unchanged completion time.

// File: rtl/sm4_core_pkg.sv
// Package: shared widths, state type and the byte-level arithmetic used by
// the SM4 datapath (GF(2^8) arithmetic, AES affine map, and the two
// nibble-table affine maps that move bytes between the two field bases).
// Assumes: AES field polynomial x^8+x^4+x^3+x+1.
package sm4_core_pkg;

    localparam int WORD_W  = 32;
    localparam int BLOCK_W = 4 * WORD_W;
    localparam int BYTE_W  = 8;
    localparam int BYTES_PER_WORD = WORD_W / BYTE_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BYTE_W-1:0] byte_t;

    // First-listed member lands in the most significant bits, which gives
    // big-endian word order straight from a 128-bit block.
    typedef struct packed {
        word_t w0;
        word_t w1;
        word_t w2;
        word_t w3;
    } state_t;

    // Multiply by x in the AES field.
    function automatic byte_t gf_xtime(input byte_t a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
    endfunction

    // Shift-and-add multiply in the AES field.
    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        byte_t acc;
        byte_t sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_xtime(sh);
        end
        return acc;
    endfunction

    // Inverse as a^254 = product of a^(2^k) for k = 1..7; zero maps to zero.
    function automatic byte_t gf_inv(input byte_t a);
        byte_t pw;
        byte_t acc;
        pw  = a;
        acc = 8'h01;
        for (int k = 1; k < BYTE_W; k++) begin
            pw  = gf_mul(pw, pw);
            acc = gf_mul(acc, pw);
        end
        return acc;
    endfunction

    function automatic byte_t rol8(input byte_t b, input int n);
        return (b << n) | (b >> (BYTE_W - n));
    endfunction

    // AES affine output map applied after inversion.
    function automatic byte_t aes_affine(input byte_t b);
        return b ^ rol8(b, 1) ^ rol8(b, 2) ^ rol8(b, 3) ^ rol8(b, 4) ^ 8'h63;
    endfunction

    // Input-side basis change, low-nibble contribution.
    function automatic byte_t to_aes_lo(input logic [3:0] n);
        case (n)
            4'h0: return 8'h01;  4'h1: return 8'h07;
            4'h2: return 8'h72;  4'h3: return 8'h74;
            4'h4: return 8'hE4;  4'h5: return 8'hE2;
            4'h6: return 8'h97;  4'h7: return 8'h91;
            4'h8: return 8'h57;  4'h9: return 8'h51;
            4'hA: return 8'h24;  4'hB: return 8'h22;
            4'hC: return 8'hB2;  4'hD: return 8'hB4;
            4'hE: return 8'hC1;  default: return 8'hC7;
        endcase
    endfunction

    // Input-side basis change, high-nibble contribution.
    function automatic byte_t to_aes_hi(input logic [3:0] n);
        case (n)
            4'h0: return 8'h00;  4'h1: return 8'hA2;
            4'h2: return 8'h49;  4'h3: return 8'hEB;
            4'h4: return 8'h09;  4'h5: return 8'hAB;
            4'h6: return 8'h40;  4'h7: return 8'hE2;
            4'h8: return 8'h12;  4'h9: return 8'hB0;
            4'hA: return 8'h5B;  4'hB: return 8'hF9;
            4'hC: return 8'h1B;  4'hD: return 8'hB9;
            4'hE: return 8'h52;  default: return 8'hF0;
        endcase
    endfunction

    // Output-side basis change, low-nibble contribution.
    function automatic byte_t from_aes_lo(input logic [3:0] n);
        case (n)
            4'h0: return 8'h34;  4'h1: return 8'h08;
            4'h2: return 8'h9D;  4'h3: return 8'hA1;
            4'h4: return 8'hCE;  4'h5: return 8'hF2;
            4'h6: return 8'h67;  4'h7: return 8'h5B;
            4'h8: return 8'h82;  4'h9: return 8'hBE;
            4'hA: return 8'h2B;  4'hB: return 8'h17;
            4'hC: return 8'h78;  4'hD: return 8'h44;
            4'hE: return 8'hD1;  default: return 8'hED;
        endcase
    endfunction

    // Output-side basis change, high-nibble contribution.
    function automatic byte_t from_aes_hi(input logic [3:0] n);
        case (n)
            4'h0: return 8'h00;  4'h1: return 8'hDC;
            4'h2: return 8'hAF;  4'h3: return 8'h73;
            4'h4: return 8'hDD;  4'h5: return 8'h01;
            4'h6: return 8'h72;  4'h7: return 8'hAE;
            4'h8: return 8'hBF;  4'h9: return 8'h63;
            4'hA: return 8'h10;  4'hB: return 8'hCC;
            4'hC: return 8'h62;  4'hD: return 8'hBE;
            4'hE: return 8'hCD;  default: return 8'h11;
        endcase
    endfunction

endpackage

// File: rtl/sm4_aes_sbox.sv
// AES forward S-box, computed rather than stored: field inverse followed by
// the AES affine map. Purely combinational.
// Assumes: caller registers around it as timing requires.
module sm4_aes_sbox
    import sm4_core_pkg::*;
(
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] dout
);

    byte_t inv_b;

    // Field inverse, then affine map.
    always_comb begin
        inv_b = gf_inv(din);
        dout  = aes_affine(inv_b);
    end

endmodule

// File: rtl/sm4_byte_sub.sv
// One SM4 byte substitution: input basis change (two nibble lookups XORed),
// AES forward S-box, output basis change (two nibble lookups XORed).
// Assumes: combinational use inside a single round cycle.
module sm4_byte_sub
    import sm4_core_pkg::*;
(
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] dout
);

    byte_t in_mapped;
    byte_t aes_out;

    // Move the byte into the AES field basis.
    always_comb begin
        in_mapped = to_aes_lo(din[3:0]) ^ to_aes_hi(din[7:4]);
    end

    sm4_aes_sbox u_aes (
        .din  (in_mapped),
        .dout (aes_out)
    );

    // Move the substituted byte back to the SM4 basis.
    always_comb begin
        dout = from_aes_lo(aes_out[3:0]) ^ from_aes_hi(aes_out[7:4]);
    end

endmodule

// File: rtl/sm4_round_fn.sv
// Combinational SM4 round: mixes three state words with the round key,
// substitutes each byte, applies the linear diffusion map and folds the
// result into the first word. Returns the shifted next state.
// Assumes: one instance evaluated per clock by the iterating controller.
module sm4_round_fn
    import sm4_core_pkg::*;
(
    input  state_t              cur,
    input  logic [WORD_W-1:0]   rkey,
    output state_t              nxt
);

    word_t mix_w;
    word_t sub_w;
    word_t lin_w;

    // Key and word mixing ahead of substitution.
    always_comb begin
        mix_w = cur.w1 ^ cur.w2 ^ cur.w3 ^ rkey;
    end

    for (genvar g = 0; g < BYTES_PER_WORD; g++) begin : g_sub
        sm4_byte_sub u_sub (
            .din  (mix_w[g*BYTE_W +: BYTE_W]),
            .dout (sub_w[g*BYTE_W +: BYTE_W])
        );
    end

    // Linear diffusion over the substituted word.
    always_comb begin
        lin_w = sub_w
              ^ {sub_w[WORD_W-3:0],  sub_w[WORD_W-1:WORD_W-2]}
              ^ {sub_w[WORD_W-11:0], sub_w[WORD_W-1:WORD_W-10]}
              ^ {sub_w[WORD_W-19:0], sub_w[WORD_W-1:WORD_W-18]}
              ^ {sub_w[WORD_W-25:0], sub_w[WORD_W-1:WORD_W-24]};
    end

    // Word roles rotate; the new word enters last.
    always_comb begin
        nxt.w0 = cur.w1;
        nxt.w1 = cur.w2;
        nxt.w2 = cur.w3;
        nxt.w3 = cur.w0 ^ lin_w;
    end

endmodule

// File: rtl/sm4_iter_core.sv
// SM4 iterated core: captures a block on start, performs NUM_ROUNDS rounds
// one per clock while requesting round keys by index, then registers the
// word-reversed result and pulses done for one cycle.
// Assumes: rk_data answers rk_idx combinationally in the same cycle;
// start while busy is dropped.
module sm4_iter_core
    import sm4_core_pkg::*;
#(
    parameter  int NUM_ROUNDS = 32,
    localparam int RW = (NUM_ROUNDS > 1) ? $clog2(NUM_ROUNDS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [BLOCK_W-1:0] block_in,
    input  logic [WORD_W-1:0]  rk_data,
    output logic [RW-1:0]      rk_idx,
    output logic               busy,
    output logic               done,
    output logic [BLOCK_W-1:0] block_out
);

    localparam logic [RW-1:0] LAST_IDX = RW'(NUM_ROUNDS - 1);

    state_t        st_q;
    state_t        st_nxt;
    logic [RW-1:0] rnd_q;
    logic          busy_q;
    logic          done_q;
    logic [BLOCK_W-1:0] out_q;
    logic          accept;
    logic          finish;

    assign accept = start && !busy_q;
    assign finish = busy_q && (rnd_q == LAST_IDX);

    sm4_round_fn u_round (
        .cur  (st_q),
        .rkey (rk_data),
        .nxt  (st_nxt)
    );

    // Running flag: set on an accepted start, cleared after the last round.
    always_ff @(posedge clk) begin
        if (!rst_n)       busy_q <= 1'b0;
        else if (accept)  busy_q <= 1'b1;
        else if (finish)  busy_q <= 1'b0;
    end

    // Round counter, doubles as the key index.
    always_ff @(posedge clk) begin
        if (!rst_n)                rnd_q <= '0;
        else if (accept || finish) rnd_q <= '0;
        else if (busy_q)           rnd_q <= rnd_q + 1'b1;
    end

    // State words: load on start, advance one round per busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)      st_q <= '0;
        else if (accept) st_q <= state_t'(block_in);
        else if (busy_q) st_q <= st_nxt;
    end

    // Completion strobe, one cycle wide.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= finish;
    end

    // Result register: reversed word order, updated only at completion.
    always_ff @(posedge clk) begin
        if (!rst_n)      out_q <= '0;
        else if (finish) out_q <= {st_nxt.w3, st_nxt.w2, st_nxt.w1, st_nxt.w0};
    end

    assign rk_idx    = rnd_q;
    assign busy      = busy_q;
    assign done      = done_q;
    assign block_out = out_q;

endmodule

// File: rtl/sm4_iter_core_chk.sv
// Protocol checker for sm4_iter_core: reset state, key index order,
// completion timing, ignored starts and result stability.
module sm4_iter_core_chk #(
    parameter  int NUM_ROUNDS = 32,
    localparam int RW = (NUM_ROUNDS > 1) ? $clog2(NUM_ROUNDS) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [RW-1:0] rk_idx,
    input logic          busy,
    input logic          done,
    input logic [127:0]  block_out
);

    localparam logic [RW-1:0] LAST_IDX = RW'(NUM_ROUNDS - 1);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && rk_idx == '0));

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R3
    first_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (rk_idx == '0));

    // R3
    key_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rk_idx != LAST_IDX) |=> (busy && rk_idx == $past(rk_idx) + 1'b1));

    // R6
    last_round_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rk_idx == LAST_IDX) |=> (done && !busy));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(block_out) |-> done);

    // R8
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && rk_idx != LAST_IDX) |=> (busy && !done));

endmodule

bind sm4_iter_core sm4_iter_core_chk #(.NUM_ROUNDS(NUM_ROUNDS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .rk_idx    (rk_idx),
    .busy      (busy),
    .done      (done),
    .block_out (block_out)
);

// File: tb/sm4_iter_core_test.sv
module sm4_iter_core_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [127:0] block_in = '0;
    logic [31:0]  rk_data;
    logic [4:0]   rk_idx;
    logic         busy;
    logic         done;
    logic [127:0] block_out;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [31:0] keys [32];
    int exp_t [256];
    int log_t [256];
    logic [7:0] sb [256];

    always #10 clk = ~clk;  // 50 MHz

    assign rk_data = keys[rk_idx];

    sm4_iter_core uut (
        .clk(clk), .rst_n(rst_n), .start(start), .block_in(block_in),
        .rk_data(rk_data), .rk_idx(rk_idx), .busy(busy), .done(done),
        .block_out(block_out)
    );

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // ---- reference model ----
    function automatic logic [7:0] xt(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
    endfunction

    localparam logic [7:0] PLO [16] = '{8'h01,8'h07,8'h72,8'h74,8'hE4,8'hE2,8'h97,8'h91,
                                        8'h57,8'h51,8'h24,8'h22,8'hB2,8'hB4,8'hC1,8'hC7};
    localparam logic [7:0] PHI [16] = '{8'h00,8'hA2,8'h49,8'hEB,8'h09,8'hAB,8'h40,8'hE2,
                                        8'h12,8'hB0,8'h5B,8'hF9,8'h1B,8'hB9,8'h52,8'hF0};
    localparam logic [7:0] QLO [16] = '{8'h34,8'h08,8'h9D,8'hA1,8'hCE,8'hF2,8'h67,8'h5B,
                                        8'h82,8'hBE,8'h2B,8'h17,8'h78,8'h44,8'hD1,8'hED};
    localparam logic [7:0] QHI [16] = '{8'h00,8'hDC,8'hAF,8'h73,8'hDD,8'h01,8'h72,8'hAE,
                                        8'hBF,8'h63,8'h10,8'hCC,8'h62,8'hBE,8'hCD,8'h11};

    // Build the SM4 byte table from exp/log tables of generator 3.
    task automatic build_tables();
        logic [7:0] g = 8'h01;
        for (int i = 0; i < 255; i++) begin
            exp_t[i] = int'(g);
            log_t[g] = i;
            g = g ^ xt(g);
        end
        for (int b = 0; b < 256; b++) begin
            logic [7:0] p, inv, s, r;
            p = PLO[b % 16] ^ PHI[b / 16];
            inv = (p == 0) ? 8'h00 : 8'(exp_t[(255 - log_t[p]) % 255]);
            s = inv ^ {inv[6:0],inv[7]} ^ {inv[5:0],inv[7:6]} ^ {inv[4:0],inv[7:5]}
                    ^ {inv[3:0],inv[7:4]} ^ 8'h63;
            r = QLO[s[3:0]] ^ QHI[s[7:4]];
            sb[b] = r;
        end
    endtask

    function automatic logic [31:0] rl(input logic [31:0] x, input int n);
        return (x << n) | (x >> (32 - n));
    endfunction

    function automatic logic [31:0] tau(input logic [31:0] x);
        return {sb[x[31:24]], sb[x[23:16]], sb[x[15:8]], sb[x[7:0]]};
    endfunction

    function automatic logic [127:0] model(input logic [127:0] blk);
        logic [31:0] x [36];
        logic [31:0] b;
        for (int i = 0; i < 4; i++) x[i] = blk[127 - 32*i -: 32];
        for (int i = 0; i < 32; i++) begin
            b = tau(x[i+1] ^ x[i+2] ^ x[i+3] ^ keys[i]);
            x[i+4] = x[i] ^ b ^ rl(b, 2) ^ rl(b, 10) ^ rl(b, 18) ^ rl(b, 24);
        end
        return {x[35], x[34], x[33], x[32]};
    endfunction

    // Standard key schedule, optionally stored reversed for decryption.
    task automatic expand_key(input logic [127:0] mk, input bit rev);
        logic [31:0] k [36];
        logic [31:0] fk [4];
        logic [31:0] ck, b;
        fk[0] = 32'hA3B1BAC6; fk[1] = 32'h56AA3350;
        fk[2] = 32'h677D9197; fk[3] = 32'hB27022DC;
        for (int i = 0; i < 4; i++) k[i] = mk[127 - 32*i -: 32] ^ fk[i];
        for (int i = 0; i < 32; i++) begin
            for (int j = 0; j < 4; j++) ck[31 - 8*j -: 8] = 8'(((4*i + j) * 7) % 256);
            b = tau(k[i+1] ^ k[i+2] ^ k[i+3] ^ ck);
            k[i+4] = k[i] ^ b ^ rl(b, 13) ^ rl(b, 23);
        end
        for (int i = 0; i < 32; i++) keys[rev ? 31 - i : i] = k[i+4];
    endtask

    // Run one block; optionally inject a start with another block at a
    // given negedge count. Returns result and negedges until done.
    task automatic run_block(input logic [127:0] blk, input int inj_at,
                             input logic [127:0] inj_blk, input string req,
                             output logic [127:0] res, output int lat);
        int bad_idx = 0;
        @(negedge clk);
        start = 1'b1; block_in = blk;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
            start = 1'b0;
            if (lat == inj_at) begin start = 1'b1; block_in = inj_blk; end
            if (lat <= 32 && (rk_idx !== 5'(lat - 1) || busy !== 1'b1)) bad_idx++;
        end while (!done && lat < 60);
        if (inj_at == 33) ;
        else start = 1'b0;
        res = block_out;
        chk(req, "R3 key index order/busy per round mismatches", 128'(bad_idx), 128'd0);
    endtask

    logic [127:0] res, res2, pt, ct;
    int lat;

    initial begin
        void'($urandom(32'h5EED_0042));
        build_tables();
        for (int i = 0; i < 32; i++) keys[i] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "busy", 128'(busy), 128'd0);
        chk("R1", "done", 128'(done), 128'd0);
        chk("R1", "rk_idx", 128'(rk_idx), 128'd0);
        chk("R1", "block_out", block_out, 128'd0);
        rst_n = 1'b1;

        // R11 / R5 / R4 / R7 standard vector
        pt = 128'h0123456789abcdeffedcba9876543210;
        expand_key(pt, 1'b0);
        run_block(pt, 0, '0, "R2", res, lat);
        chk("R11", "standard vector", res, 128'h681edf34d206965e86b3e94f536e4246);
        chk("R5", "S-box via standard vector", res, 128'h681edf34d206965e86b3e94f536e4246);
        chk("R6", "latency in cycles", 128'(lat), 128'd33);
        chk("R6", "busy low with done", 128'(busy), 128'd0);
        @(negedge clk);
        chk("R6", "done width one cycle", 128'(done), 128'd0);
        repeat (4) @(negedge clk);
        chk("R7", "block_out held after done", block_out, 128'h681edf34d206965e86b3e94f536e4246);

        // R10 decryption with reversed keys
        ct = res;
        expand_key(pt, 1'b1);
        run_block(ct, 0, '0, "R10", res, lat);
        chk("R10", "decrypt returns plaintext", res, pt);

        // R4 / R7 random round keys and blocks against model
        for (int t = 0; t < 12; t++) begin
            logic [127:0] blk;
            for (int i = 0; i < 32; i++) keys[i] = $urandom();
            blk = {$urandom(), $urandom(), $urandom(), $urandom()};
            if (t == 0) begin blk = '0; for (int i = 0; i < 32; i++) keys[i] = '0; end
            if (t == 1) begin blk = '1; for (int i = 0; i < 32; i++) keys[i] = '1; end
            run_block(blk, 0, '0, "R4", res, lat);
            chk("R4", "random block vs model", res, model(blk));
        end

        // R8 start while busy, mid-run and in the last round cycle
        expand_key(pt, 1'b0);
        run_block(pt, 10, 128'hDEAD, "R8", res, lat);
        chk("R8", "mid-run start ignored: result", res, 128'h681edf34d206965e86b3e94f536e4246);
        chk("R8", "mid-run start ignored: latency", 128'(lat), 128'd33);
        run_block(pt, 32, 128'hBEEF, "R8", res, lat);
        chk("R8", "last-round start ignored: result", res, 128'h681edf34d206965e86b3e94f536e4246);
        @(negedge clk);
        chk("R8", "no restart after last-round start", 128'(busy), 128'd0);

        // R9 start in the same cycle as done
        for (int i = 0; i < 32; i++) keys[i] = $urandom();
        res2 = {$urandom(), $urandom(), $urandom(), $urandom()};
        run_block(128'h00112233445566778899aabbccddeeff, 33, res2, "R9", res, lat);
        chk("R9", "first result intact", res, model(128'h00112233445566778899aabbccddeeff));
        @(negedge clk);
        start = 1'b0;
        chk("R9", "busy after start with done", 128'(busy), 128'd1);
        lat = 1;
        while (!done && lat < 60) begin @(negedge clk); lat++; end
        chk("R9", "back-to-back latency", 128'(lat), 128'd33);
        chk("R9", "back-to-back result", block_out, model(res2));

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R6 watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule